// File: doc/BRIEF.md
# Power-Domain State Corruption Injector

This block stands in for one switchable power domain inside an emulation model, where unknown values do not exist. It keeps the domain's bank of state bits and the path from the domain's inputs to that bank. When the domain loses power, the block overwrites the state with a chosen pattern: seeded pseudo-random bits, the inverted bits, all zeros or all ones. While the domain stays dark it drives fresh pseudo-random values on the domain outputs every cycle. It can also scramble the values the domain sees on its inputs, and it can re-scramble the state at a fixed cycle interval.

When power returns, nothing is cleaned up. The domain runs on from whatever the corruption left behind until its own synchronous reset is seen on a clock edge while it is powered. A missing reset in the power-up sequence therefore shows up as garbage rather than being hidden. Runs repeat exactly for a given seed and vary when the seed changes.

Top module: `pwr_corrupt_injector`

## Requirements
- R1: At the first clock edge where `pwrEn` is low and was high at the previous edge (the off edge), the state is replaced according to `policy` as sampled at that edge: 2'b00 takes the low W bits of the LFSR value held before that edge, 2'b01 inverts every bit, 2'b10 clears every bit, 2'b11 sets every bit. `policy` has no effect at any other edge.
- R2: While `pwrEn` is low, `domOut` shows the upper W bits of the current LFSR register, which changes every cycle. While `pwrEn` is high, `domOut` equals the state.
- R3: While off, a nonzero `interval` of N makes the state take the low W bits of the pre-edge LFSR value at every Nth off-period edge after the off edge. The count restarts at the off edge and after each re-randomization. An `interval` of 0 disables this.
- R4: While `pwrEn` is low and `corruptInEn` is high, `inView` shows the low W bits of the current LFSR register. Otherwise `inView` equals `wrData`.
- R5: The LFSR is 32 bits wide and advances at every clock edge outside `sysRst` as a right-shifting Galois register: shift right by one, then XOR with 32'h80200003 if the bit shifted out was 1. During `sysRst` it loads `seed`, or 32'hACE12468 when `seed` is zero.
- R6: A power-on edge applies no reset. The state keeps its corrupted value until `domRst` or `wrEn` is seen at an edge while `pwrEn` is high.
- R7: While `pwrEn` is low, `wrEn`, `wrData` and `domRst` do not change the state.
- R8: While `pwrEn` is high, `domRst` clears the state at the next edge and takes priority over `wrEn`. Otherwise `wrEn` loads `wrData`.
- R9: `sysRst` is synchronous and clears the state and the interval count. It records the current `pwrEn` so that no off edge is seen on the first edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sysRst | input | 1 | Global synchronous reset, also loads the seed |
| pwrEn | input | 1 | Domain power enable, high = powered |
| policy | input | 2 | Corruption policy applied at the off edge |
| interval | input | 16 | Off-period re-randomization interval in cycles, 0 = off |
| corruptInEn | input | 1 | Also scramble the domain's inputs while off |
| seed | input | 32 | LFSR start value |
| wrEn | input | 1 | Functional state write strobe |
| wrData | input | 16 | Functional write data, also the domain input |
| domRst | input | 1 | Domain synchronous reset |
| stateOut | output | 16 | Current state bank |
| domOut | output | 16 | Domain outputs as seen by the rest of the chip |
| inView | output | 16 | Domain inputs as seen inside the domain |

## Verification
A wrong state register appears on `domOut` in the same cycle whenever the domain is powered, and on `stateOut` always, one edge after the faulty update. A wrong LFSR step appears on `domOut` in the very next off cycle. Because the bank copies LFSR bits at the off edge, the step also corrupts every later random state, so a single bad tap spreads into every following comparison. A miscounted interval shows up exactly at the expected re-randomization edge, as a state that failed to change or changed too early.

// File: rtl/pci_pkg.sv
package pci_pkg;
  typedef enum logic [1:0] {
    POL_RANDOM = 2'b00,
    POL_INVERT = 2'b01,
    POL_ZERO   = 2'b10,
    POL_ONE    = 2'b11
  } policy_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    live;
    logic    offEdge;
    logic    reRand;
    policy_e pol;
  } strobe_t;

  localparam int unsigned LFSR_W = 32;
  localparam logic [LFSR_W-1:0] LFSR_MASK     = 32'h8020_0003;
  localparam logic [LFSR_W-1:0] SEED_FALLBACK = 32'hACE1_2468;
endpackage

// File: rtl/pci_ctrl.sv
module pci_ctrl
  import pci_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             sysRst,
  input  logic             pwrEn,
  input  logic [1:0]       policy,
  input  logic [CNT_W-1:0] interval,
  output strobe_t          st
);
  localparam int unsigned CW1 = CNT_W + 1;

  logic             pwrQ;
  logic [CNT_W-1:0] cnt;
  logic [CW1-1:0]   cntNext;
  logic             offDark;

  assign cntNext = {1'b0, cnt} + CW1'(1);
  assign offDark = !pwrEn && !pwrQ;

  always_comb begin
    st.live    = pwrEn;
    st.offEdge = !pwrEn && pwrQ;
    st.pol     = policy_e'(policy);
    st.reRand  = offDark && (interval != '0) && (cntNext == {1'b0, interval});
  end

  always_ff @(posedge clk) begin
    if (sysRst) begin
      pwrQ <= pwrEn;
      cnt  <= '0;
    end else begin
      pwrQ <= pwrEn;
      if (!offDark || st.reRand) begin
        cnt <= '0;
      end else if (interval != '0) begin
        cnt <= cntNext[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/pci_datapath.sv
module pci_datapath
  import pci_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk,
  input  logic              sysRst,
  input  strobe_t           st,
  input  logic [LFSR_W-1:0] seed,
  input  logic              corruptInEn,
  input  logic              wrEn,
  input  logic [W-1:0]      wrData,
  input  logic              domRst,
  output logic [W-1:0]      stateOut,
  output logic [W-1:0]      domOut,
  output logic [W-1:0]      inView
);
  logic [LFSR_W-1:0] lfsr;
  logic [LFSR_W-1:0] lfsrNext;
  logic [W-1:0]      stateQ;
  logic [W-1:0]      lowRand;
  logic [W-1:0]      highRand;
  logic [W-1:0]      policyVal;

  assign lfsrNext = (lfsr >> 1) ^ (lfsr[0] ? LFSR_MASK : '0);
  assign lowRand  = lfsr[W-1:0];
  assign highRand = lfsr[LFSR_W-1 -: W];

  always_comb begin
    unique case (st.pol)
      POL_RANDOM: policyVal = lowRand;
      POL_INVERT: policyVal = ~stateQ;
      POL_ZERO:   policyVal = '0;
      default:    policyVal = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (sysRst) begin
      lfsr   <= (seed == '0) ? SEED_FALLBACK : seed;
      stateQ <= '0;
    end else begin
      lfsr <= lfsrNext;
      if (st.offEdge) begin
        stateQ <= policyVal;
      end else if (st.reRand) begin
        stateQ <= lowRand;
      end else if (st.live) begin
        if (domRst)    stateQ <= '0;
        else if (wrEn) stateQ <= wrData;
      end
    end
  end

  assign stateOut = stateQ;
  assign domOut   = st.live ? stateQ : highRand;
  assign inView   = (!st.live && corruptInEn) ? lowRand : wrData;
endmodule

// File: rtl/pwr_corrupt_injector.sv
module pwr_corrupt_injector
  import pci_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              sysRst,
  input  logic              pwrEn,
  input  logic [1:0]        policy,
  input  logic [CNT_W-1:0]  interval,
  input  logic              corruptInEn,
  input  logic [LFSR_W-1:0] seed,
  input  logic              wrEn,
  input  logic [W-1:0]      wrData,
  input  logic              domRst,
  output logic [W-1:0]      stateOut,
  output logic [W-1:0]      domOut,
  output logic [W-1:0]      inView
);
  strobe_t st;

  pci_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .sysRst(sysRst), .pwrEn(pwrEn),
    .policy(policy), .interval(interval), .st(st)
  );

  pci_datapath #(.W(W)) uData (
    .clk(clk), .sysRst(sysRst), .st(st), .seed(seed),
    .corruptInEn(corruptInEn), .wrEn(wrEn), .wrData(wrData),
    .domRst(domRst), .stateOut(stateOut), .domOut(domOut), .inView(inView)
  );
endmodule

// File: rtl/pci_checker.sv
module pci_checker
  import pci_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             sysRst,
  input logic             pwrEn,
  input logic [1:0]       policy,
  input logic [CNT_W-1:0] interval,
  input logic             wrEn,
  input logic             domRst,
  input strobe_t          st,
  input logic [W-1:0]     stateOut
);
  assert_zero_policy_R1: assert property (@(posedge clk) disable iff (sysRst)
    (st.offEdge && policy == 2'b10) |=> (stateOut == '0));

  assert_one_policy_R1: assert property (@(posedge clk) disable iff (sysRst)
    (st.offEdge && policy == 2'b11) |=> (stateOut == '1));

  assert_invert_policy_R1: assert property (@(posedge clk) disable iff (sysRst)
    (st.offEdge && policy == 2'b01) |=> (stateOut == ~$past(stateOut)));

  assert_rerand_gated_R3: assert property (@(posedge clk) disable iff (sysRst)
    st.reRand |-> (!pwrEn && interval != '0 && !st.offEdge));

  assert_no_idle_change_R6: assert property (@(posedge clk) disable iff (sysRst)
    (pwrEn && !domRst && !wrEn) |=> $stable(stateOut));

  assert_off_ignores_R7: assert property (@(posedge clk) disable iff (sysRst)
    (!pwrEn && !st.offEdge && !st.reRand) |=> $stable(stateOut));

  assert_dom_reset_R8: assert property (@(posedge clk) disable iff (sysRst)
    (pwrEn && domRst) |=> (stateOut == '0));
endmodule

bind pwr_corrupt_injector pci_checker #(.W(W), .CNT_W(CNT_W)) uChk (
  .clk(clk), .sysRst(sysRst), .pwrEn(pwrEn), .policy(policy),
  .interval(interval), .wrEn(wrEn), .domRst(domRst), .st(st),
  .stateOut(stateOut)
);

// File: tb/tb_pwr_corrupt_injector.sv
`timescale 1ns/1ps
module tb_pwr_corrupt_injector;
  localparam int W = 16;

  typedef struct {
    string      req;
    logic [15:0] eState;
    logic [15:0] eOut;
    logic [15:0] eIn;
  } item_t;

  logic        clk = 1'b0;
  logic        sysRst = 1'b1;
  logic        pwrEn = 1'b1;
  logic [1:0]  policy = 2'b00;
  logic [15:0] interval = 16'd0;
  logic        corruptInEn = 1'b0;
  logic [31:0] seed = 32'h1234_5678;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = 16'h0;
  logic        domRst = 1'b0;
  logic [15:0] stateOut, domOut, inView;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  item_t sbq[$];

  // reference model state
  logic [31:0] mLfsr;
  logic [15:0] mState;
  logic [15:0] mCnt;
  logic        mPwrQ;

  always #5 clk = ~clk;

  pwr_corrupt_injector dut (
    .clk(clk), .sysRst(sysRst), .pwrEn(pwrEn), .policy(policy),
    .interval(interval), .corruptInEn(corruptInEn), .seed(seed),
    .wrEn(wrEn), .wrData(wrData), .domRst(domRst),
    .stateOut(stateOut), .domOut(domOut), .inView(inView)
  );

  function automatic logic [31:0] stepLfsr(input logic [31:0] v);
    return (v >> 1) ^ (v[0] ? 32'h8020_0003 : 32'h0);
  endfunction

  // driver: model one edge from the current inputs, push expected outputs
  task automatic cyc(input string req);
    item_t it;
    logic [31:0] old;
    old = mLfsr;
    if (sysRst) begin
      mLfsr  = (seed == 0) ? 32'hACE1_2468 : seed;
      mState = '0;
      mCnt   = '0;
    end else begin
      if (!pwrEn && mPwrQ) begin
        case (policy)
          2'b00: mState = old[15:0];
          2'b01: mState = ~mState;
          2'b10: mState = '0;
          default: mState = '1;
        endcase
        mCnt = '0;
      end else if (!pwrEn) begin
        if (interval != 0) begin
          if (mCnt + 16'd1 == interval) begin
            mState = old[15:0];
            mCnt = '0;
          end else mCnt = mCnt + 16'd1;
        end
      end else begin
        mCnt = '0;
        if (domRst) mState = '0;
        else if (wrEn) mState = wrData;
      end
      mLfsr = stepLfsr(old);
    end
    mPwrQ = pwrEn;
    it.req    = req;
    it.eState = mState;
    it.eOut   = pwrEn ? mState : mLfsr[31:16];
    it.eIn    = (!pwrEn && corruptInEn) ? mLfsr[15:0] : wrData;
    sbq.push_back(it);
    @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        checks++;
        if (stateOut !== it.eState || domOut !== it.eOut || inView !== it.eIn) begin
          errors++;
          $display("FAIL %s: state=%h out=%h in=%h expected state=%h out=%h in=%h",
                   it.req, stateOut, domOut, inView, it.eState, it.eOut, it.eIn);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R9 / R5: reset with a nonzero seed
    cyc("R9"); cyc("R5");
    sysRst = 0;
    // R8: functional writes and domain reset while powered
    wrEn = 1; wrData = 16'hA5C3; cyc("R8");
    domRst = 1; wrData = 16'h5555; cyc("R8");
    domRst = 0; wrData = 16'h1234; cyc("R8");
    wrEn = 0; cyc("R6");
    // R1 random policy, R2 fresh outputs, R7 ignored writes/reset
    policy = 2'b00; pwrEn = 0; cyc("R1");
    policy = 2'b11; wrEn = 1; wrData = 16'hFFFF; cyc("R7");
    domRst = 1; cyc("R7");
    domRst = 0; wrEn = 0;
    for (int i = 0; i < 4; i++) cyc("R2");
    // R6: power-on keeps the corrupted state
    pwrEn = 1; cyc("R6"); cyc("R6"); cyc("R6");
    domRst = 1; cyc("R6");
    domRst = 0;
    // R1 invert, policy changes while off are ignored
    wrEn = 1; wrData = 16'h00FF; cyc("R8");
    wrEn = 0; policy = 2'b01; pwrEn = 0; cyc("R1");
    policy = 2'b10; cyc("R1"); cyc("R1");
    pwrEn = 1; cyc("R6");
    // R1 zeros, then ones
    pwrEn = 0; policy = 2'b10; cyc("R1"); cyc("R2");
    pwrEn = 1; cyc("R6");
    pwrEn = 0; policy = 2'b11; cyc("R1"); cyc("R2");
    pwrEn = 1; cyc("R6");
    // R3 periodic re-randomization with R4 input corruption
    interval = 16'd3; corruptInEn = 1; wrData = 16'h3C3C;
    pwrEn = 0; policy = 2'b10; cyc("R1");
    for (int i = 0; i < 10; i++) cyc("R3");
    corruptInEn = 0; cyc("R4"); cyc("R4");
    interval = 16'd1; cyc("R3"); cyc("R3");
    interval = 16'd0; for (int i = 0; i < 3; i++) cyc("R3");
    pwrEn = 1; cyc("R4");
    corruptInEn = 1; cyc("R4");
    // R5: zero seed falls back to a fixed constant
    sysRst = 1; seed = 32'h0; cyc("R5"); cyc("R9");
    sysRst = 0; corruptInEn = 1;
    pwrEn = 0; policy = 2'b00; cyc("R5");
    for (int i = 0; i < 5; i++) cyc("R5");
    // R9: reset while off records pwrEn, no off edge afterwards
    sysRst = 1; seed = 32'hDEAD_BEEF; cyc("R9");
    sysRst = 0; cyc("R9"); cyc("R9");
    pwrEn = 1; cyc("R6");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule